// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Timing Controller

This block is the master side of an external expansion bus on which address and data share one set of wires. An internal client raises a request with a direction, an address and (for writes) data. The controller then runs a fixed sequence of bus phases. First comes an address phase with the latch enable high. Then one fixed address-hold cycle, a data setup phase, an active-low read or write strobe, a hold phase and a recovery gap. After that it returns to idle. The length of each phase comes from a static timing configuration word, in cycles of the bus clock.

The controller drives the shared bus through a separate output vector and output enable, so a pad ring outside the block can form the tri-state. Read data is sampled from the bus input on the last strobe cycle. It is presented to the client together with a one-cycle acknowledge on the last hold cycle. The request inputs and the configuration word are captured when an access is accepted, so they may change freely while the access runs.

The state machine has seven states. IDLE goes to ADDR when a request is present. ADDR goes to AHOLD when its counter expires, and AHOLD always goes to SETUP after one cycle. SETUP goes to STROBE, STROBE goes to HOLD, HOLD goes to RECOV and RECOV goes back to IDLE. Each of these last transitions happens when the phase counter reaches zero. Every transition reloads a shared phase counter with the next phase's length minus one.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While reset is held, and afterwards until a request arrives: latch enable low, chip select, read strobe and write strobe high (inactive), bus output enable low, acknowledge low, read data zero.
- R2: The latch enable is high for exactly A+1 cycles, where A is cfg_timing[1:0]. It rises in the cycle after a request is accepted. Throughout this phase the bus output enable is high and the bus carries the request address.
- R3: In the single cycle after the latch enable falls, the address is still driven. Chip select goes low in that cycle. Chip select is never low while the latch enable is high.
- R4: On a write, the write data is driven with output enable high for exactly S+1 cycles before the write strobe falls. S is cfg_timing[3:2].
- R5: The read or write strobe is low for exactly W+1 consecutive cycles, where W is cfg_timing[7:4]. During a write strobe the bus carries the write data.
- R6: On a read, the output enable is low from the start of the setup phase until the access ends. Read data is the bus input value sampled at the clock edge that ends the last strobe cycle.
- R7: After the strobe rises, chip select stays low for exactly H+1 cycles, where H is cfg_timing[9:8]. On a write, the bus keeps carrying the write data with output enable high during those cycles.
- R8: After chip select rises, there are exactly V+1 recovery cycles with every control inactive, where V is cfg_timing[13:10]. At least one idle cycle follows before the next latch enable pulse.
- R9: The acknowledge is high for exactly one cycle, the last cycle of the hold phase. On a read, rdata_o holds the captured value in that cycle.
- R10: A request is accepted only in idle. A request held high through recovery starts no access until recovery and one idle cycle have passed. Address, data, direction and configuration changed during an access do not affect it.
- R11: The read and write strobes are never low at the same time, and neither is ever low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all timing counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled in idle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | BUS_W | Access address |
| req_wdata_i | input | BUS_W | Write data |
| cfg_timing_i | input | 14 | Phase lengths minus one: [1:0] address, [3:2] setup, [7:4] strobe, [9:8] hold, [13:10] recovery |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | BUS_W | Captured read data |
| ale_o | output | 1 | Address latch enable, active high |
| cs_n_o | output | 1 | Chip select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| ad_o | output | BUS_W | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | BUS_W | Shared bus input value |

## Verification
All bus outputs are decoded from the state register. Each one therefore changes one clock edge after the transition that causes it. The latch enable first shows in the cycle after the accepting edge. Each later phase starts the cycle after the previous counter reaches zero. The bench indexes every access by the cycle count since the accepting edge and derives each phase boundary from the configuration fields it applied. It compares all controls at the falling edge of every cycle of the access, so a phase one cycle long or short fails at the exact boundary. Read data and the acknowledge are checked in the cycle the bench predicts for the last hold cycle. The simulated device changes its bus value on every strobe cycle, so sampling on any other strobe cycle gives a wrong value.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int CNT_W  = 4;
    localparam int SHORT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AHOLD,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_RECOV
    } mbc_state_e;

    // Packed timing word; first member is the most significant field.
    typedef struct packed {
        logic [CNT_W-1:0]   recov;
        logic [SHORT_W-1:0] hold;
        logic [CNT_W-1:0]   strobe;
        logic [SHORT_W-1:0] setup;
        logic [SHORT_W-1:0] addr;
    } mbc_cfg_t;

    localparam int CFG_W = $bits(mbc_cfg_t);

endpackage

// File: rtl/mbc_phase_timer.sv
module mbc_phase_timer
    import mbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/mbc_fsm.sv
module mbc_fsm
    import mbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [SHORT_W-1:0] first_len,
    input  logic [SHORT_W-1:0] setup_len,
    input  logic [CNT_W-1:0]   strobe_len,
    input  logic [SHORT_W-1:0] hold_len,
    input  logic [CNT_W-1:0]   recov_len,
    input  logic               done,
    output logic               load,
    output logic [CNT_W-1:0]   load_val,
    output logic               accept,
    output logic               ale,
    output logic               cs_act,
    output logic               strobe_act,
    output logic               addr_phase,
    output logic               data_phase,
    output logic               capture,
    output logic               ack
);

    mbc_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions and counter reload
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_i) begin
                state_d  = ST_ADDR;
                load     = 1'b1;
                load_val = CNT_W'(first_len);
                accept   = 1'b1;
            end
            ST_ADDR: if (done) begin
                state_d  = ST_AHOLD;
                load     = 1'b1;
                load_val = '0;
            end
            ST_AHOLD: begin
                state_d  = ST_SETUP;
                load     = 1'b1;
                load_val = CNT_W'(setup_len);
            end
            ST_SETUP: if (done) begin
                state_d  = ST_STROBE;
                load     = 1'b1;
                load_val = strobe_len;
            end
            ST_STROBE: if (done) begin
                state_d  = ST_HOLD;
                load     = 1'b1;
                load_val = CNT_W'(hold_len);
            end
            ST_HOLD: if (done) begin
                state_d  = ST_RECOV;
                load     = 1'b1;
                load_val = recov_len;
            end
            ST_RECOV: if (done) begin
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        ale        = 1'b0;
        cs_act     = 1'b0;
        strobe_act = 1'b0;
        addr_phase = 1'b0;
        data_phase = 1'b0;
        capture    = 1'b0;
        ack        = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ADDR:   begin ale = 1'b1; addr_phase = 1'b1; end
            ST_AHOLD:  begin cs_act = 1'b1; addr_phase = 1'b1; end
            ST_SETUP:  begin cs_act = 1'b1; data_phase = 1'b1; end
            ST_STROBE: begin
                cs_act     = 1'b1;
                data_phase = 1'b1;
                strobe_act = 1'b1;
                capture    = done;
            end
            ST_HOLD:   begin cs_act = 1'b1; data_phase = 1'b1; ack = done; end
            ST_RECOV:  ;
            default:   ;
        endcase
    end

endmodule

// File: rtl/mbc_bus_drive.sv
module mbc_bus_drive
    import mbc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept,
    input  logic               req_we_i,
    input  logic [BUS_W-1:0]   req_addr_i,
    input  logic [BUS_W-1:0]   req_wdata_i,
    input  mbc_cfg_t           cfg_i,
    input  logic               addr_phase,
    input  logic               data_phase,
    input  logic               capture,
    input  logic [BUS_W-1:0]   ad_i,
    output logic               we_q,
    output logic [SHORT_W-1:0] setup_q,
    output logic [CNT_W-1:0]   strobe_q,
    output logic [SHORT_W-1:0] hold_q,
    output logic [CNT_W-1:0]   recov_q,
    output logic [BUS_W-1:0]   ad_o,
    output logic               ad_oe,
    output logic [BUS_W-1:0]   rdata
);

    logic [BUS_W-1:0] addr_q, wdata_q;

    // Per-access capture of request and timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            setup_q  <= '0;
            strobe_q <= '0;
            hold_q   <= '0;
            recov_q  <= '0;
        end else if (accept) begin
            we_q     <= req_we_i;
            addr_q   <= req_addr_i;
            wdata_q  <= req_wdata_i;
            setup_q  <= cfg_i.setup;
            strobe_q <= cfg_i.strobe;
            hold_q   <= cfg_i.hold;
            recov_q  <= cfg_i.recov;
        end
    end

    // Read sample on the final strobe cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata <= '0;
        else if (capture && !we_q) rdata <= ad_i;
    end

    assign ad_o  = addr_phase ? addr_q : wdata_q;
    assign ad_oe = addr_phase | (we_q & data_phase);

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             req_we_i,
    input  logic [BUS_W-1:0] req_addr_i,
    input  logic [BUS_W-1:0] req_wdata_i,
    input  logic [CFG_W-1:0] cfg_timing_i,
    output logic             ack_o,
    output logic [BUS_W-1:0] rdata_o,
    output logic             ale_o,
    output logic             cs_n_o,
    output logic             wr_n_o,
    output logic             rd_n_o,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o,
    input  logic [BUS_W-1:0] ad_i
);

    mbc_cfg_t           cfg;
    logic               load, done, accept;
    logic [CNT_W-1:0]   load_val;
    logic               cs_act, strobe_act, addr_phase, data_phase, capture;
    logic               we_q;
    logic [SHORT_W-1:0] setup_q, hold_q;
    logic [CNT_W-1:0]   strobe_q, recov_q;

    assign cfg = mbc_cfg_t'(cfg_timing_i);

    mbc_phase_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    mbc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .first_len  (cfg.addr),
        .setup_len  (setup_q),
        .strobe_len (strobe_q),
        .hold_len   (hold_q),
        .recov_len  (recov_q),
        .done       (done),
        .load       (load),
        .load_val   (load_val),
        .accept     (accept),
        .ale        (ale_o),
        .cs_act     (cs_act),
        .strobe_act (strobe_act),
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .capture    (capture),
        .ack        (ack_o)
    );

    mbc_bus_drive #(.BUS_W(BUS_W)) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_we_i    (req_we_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .cfg_i       (cfg),
        .addr_phase  (addr_phase),
        .data_phase  (data_phase),
        .capture     (capture),
        .ad_i        (ad_i),
        .we_q        (we_q),
        .setup_q     (setup_q),
        .strobe_q    (strobe_q),
        .hold_q      (hold_q),
        .recov_q     (recov_q),
        .ad_o        (ad_o),
        .ad_oe       (ad_oe_o),
        .rdata       (rdata_o)
    );

    assign cs_n_o = ~cs_act;
    assign wr_n_o = ~(strobe_act & we_q);
    assign rd_n_o = ~(strobe_act & ~we_q);

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
    input logic clk,
    input logic rst_n,
    input logic ale_o,
    input logic cs_n_o,
    input logic wr_n_o,
    input logic rd_n_o,
    input logic ad_oe_o,
    input logic ack_o
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n_o && !rd_n_o)); // R11

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o || !rd_n_o) |-> !cs_n_o); // R11

    AST_ALE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> cs_n_o); // R3

    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> ad_oe_o); // R2

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_o) |-> (!cs_n_o && ad_oe_o)); // R3

    AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> ad_oe_o); // R5

    AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o); // R6

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o); // R9

    AST_ACK_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (!cs_n_o && wr_n_o && rd_n_o)); // R9

endmodule

bind mux_bus_ctrl mbc_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale_o   (ale_o),
    .cs_n_o  (cs_n_o),
    .wr_n_o  (wr_n_o),
    .rd_n_o  (rd_n_o),
    .ad_oe_o (ad_oe_o),
    .ack_o   (ack_o)
);

// File: tb/mux_bus_ctrl_bench.sv
`timescale 1ns/1ps
module mux_bus_ctrl_bench;
    import mbc_pkg::*;

    localparam int BUS_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic             req_we = 1'b0;
    logic [BUS_W-1:0] req_addr = '0;
    logic [BUS_W-1:0] req_wdata = '0;
    logic [CFG_W-1:0] cfg = '0;
    logic             ack, ale, cs_n, wr_n, rd_n, ad_oe;
    logic [BUS_W-1:0] rdata, ad_o, ad_i;
    logic [BUS_W-1:0] dev_addr = '0;
    logic [BUS_W-1:0] strb_cnt = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mux_bus_ctrl #(.BUS_W(BUS_W)) u_mux_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .cfg_timing_i(cfg),
        .ack_o(ack), .rdata_o(rdata), .ale_o(ale), .cs_n_o(cs_n),
        .wr_n_o(wr_n), .rd_n_o(rd_n), .ad_o(ad_o), .ad_oe_o(ad_oe), .ad_i(ad_i)
    );

    // Device model: value moves on every strobe cycle
    always @(posedge clk) begin
        if (!rd_n) strb_cnt <= strb_cnt + 1'b1;
        else       strb_cnt <= '0;
    end
    assign ad_i = rd_n ? 16'hDEAD : ((dev_addr ^ 16'h5A5A) + strb_cnt);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [BUS_W-1:0] exp_read(input logic [BUS_W-1:0] a,
                                                  input mbc_cfg_t c);
        return (a ^ 16'h5A5A) + BUS_W'(c.strobe);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Called at a negedge; returns at the negedge of the first idle cycle
    task automatic access(input bit we, input logic [BUS_W-1:0] a,
                          input logic [BUS_W-1:0] d, input mbc_cfg_t c,
                          input bit keep);
        int l1, l2, l3, l4, l5, b1, b2, b3, b4, b5, tot;
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; cfg = c;
        dev_addr = a;
        l1 = int'(c.addr) + 1;   l2 = int'(c.setup) + 1;
        l3 = int'(c.strobe) + 1; l4 = int'(c.hold) + 1;
        l5 = int'(c.recov) + 1;
        b1 = l1; b2 = b1 + 1; b3 = b2 + l2; b4 = b3 + l3; b5 = b4 + l4;
        tot = b5 + l5;
        for (int i = 0; i <= tot; i++) begin
            logic e_ale, e_csn, e_wrn, e_rdn, e_oe, e_ack;
            logic [BUS_W-1:0] e_ad;
            string tag;
            @(negedge clk);
            if (i == 1) begin
                // R10: scribble request and configuration mid-access
                req_we = ~we; req_addr = ~a; req_wdata = ~d;
                cfg = 14'($urandom);
            end
            e_ale = (i < b1);
            e_csn = !(i >= b1 && i < b5);
            e_wrn = !(we && i >= b3 && i < b4);
            e_rdn = !(!we && i >= b3 && i < b4);
            e_oe  = (i < b2) || (we && i >= b2 && i < b5);
            e_ack = (i == b5 - 1);
            e_ad  = (i < b2) ? a : d;
            if (i < b1)      tag = "R2";
            else if (i < b2) tag = "R3";
            else if (i < b3) tag = we ? "R4" : "R6";
            else if (i < b4) tag = "R5";
            else if (i < b5) tag = "R7";
            else if (i < tot) tag = "R8";
            else             tag = "R10";
            chk({ale, cs_n, wr_n, rd_n, ad_oe} == {e_ale, e_csn, e_wrn, e_rdn, e_oe},
                tag, {27'd0, ale, cs_n, wr_n, rd_n, ad_oe},
                {27'd0, e_ale, e_csn, e_wrn, e_rdn, e_oe});
            chk(ack == e_ack, "R9 ack", {31'd0, ack}, {31'd0, e_ack});
            chk(!(!wr_n && !rd_n), "R11 strobes", {30'd0, wr_n, rd_n}, 32'd3);
            if (e_oe) chk(ad_o == e_ad, tag, {16'd0, ad_o}, {16'd0, e_ad});
            if (e_ack && !we)
                chk(rdata == exp_read(a, c), "R6 R9 rdata", {16'd0, rdata},
                    {16'd0, exp_read(a, c)});
            if (ack && !keep) req = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        finish_run();
    end

    initial begin : stim
        mbc_cfg_t c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ale, cs_n, wr_n, rd_n, ad_oe, ack} == 6'b011100, "R1 reset ctl",
            {26'd0, ale, cs_n, wr_n, rd_n, ad_oe, ack}, 32'h1C);
        chk(rdata == '0, "R1 reset rdata", {16'd0, rdata}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ale, cs_n, wr_n, rd_n, ad_oe, ack} == 6'b011100, "R1 idle ctl",
            {26'd0, ale, cs_n, wr_n, rd_n, ad_oe, ack}, 32'h1C);

        // Directed: shortest and longest timing, both directions
        c = '0;
        access(1'b1, 16'h1234, 16'hBEEF, c, 1'b0);
        access(1'b0, 16'h0F0F, 16'h0000, c, 1'b0);
        c = '1;
        access(1'b1, 16'hFFFF, 16'h0001, c, 1'b0);
        access(1'b0, 16'h8001, 16'h0000, c, 1'b1);
        // R10: request kept high, back-to-back
        c = 14'h2A5;
        access(1'b0, 16'h4242, 16'h0000, c, 1'b1);
        access(1'b1, 16'h7E7E, 16'hC3C3, c, 1'b0);

        // Constrained random
        for (int n = 0; n < 60; n++) begin
            c = 14'($urandom);
            access(1'($urandom), 16'($urandom), 16'($urandom), c, 1'($urandom));
            if (!req) begin
                int gap;
                gap = int'($urandom % 4);
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk({ale, cs_n, ack} == 3'b010, "R10 idle",
                        {29'd0, ale, cs_n, ack}, 32'd2);
                end
            end
        end
        req = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule